// File: doc/BRIEF.md
# Bus Mode Configuration Register

This block is one configuration word in the slave I/O port of a bus-mastering network controller. It holds four live bits. The first is a constant marker bit. The second is a sticky flag that records whether the host drives the port with 32-bit accesses. The last two are separate enables that allow linear bursting on memory reads and on memory writes.

The block watches every host I/O access on the port. It decodes each access from its offset, its byte enables and its write strobe. Each bit follows its own reset and write rules. Three inputs act on the state: a hard reset, a soft reset and a stop command. An external burst-permit pin is brought in through a two-flop synchronizer. While that pin is low, both burst enables are forced off.

The rest of the chip sees the current mode and enable levels directly. The host sees the word through the read data bus. Bit positions within the word: bit 8 is the marker, bit 7 is the 32-bit mode flag, bit 6 is the read-burst enable and bit 5 is the write-burst enable. All other bits read as zero.

Top module: `bus_mode_cfg`

## Requirements
- R1: Bit 8 of the word reads back as one on every read of the register. This holds after hard reset and is not changed by soft reset, stop or any write.
- R2: The mode flag (bit 7, output `dword_mode`) is zero after hard reset. It becomes one on the clock edge that ends a write to offset `MODE_OFS` (default 0x10) with all four byte enables set.
- R3: The mode flag does not change on a write to `MODE_OFS` that has fewer than four byte enables set, or on a read of that offset.
- R4: A host write to the register's own offset (`CFG_OFS`, default 0x12) with data bit 7 set or clear leaves the mode flag unchanged.
- R5: Once the mode flag is one, soft reset and stop leave it at one. Only hard reset returns it to zero.
- R6: Both burst enables are zero after hard reset. While the burst permit is in effect, a write to `CFG_OFS` with byte enable 0 set loads data bit 6 into the read-burst enable and data bit 5 into the write-burst enable on that clock edge. A write to `CFG_OFS` with byte enable 0 clear leaves both enables unchanged.
- R7: Soft reset and stop leave both burst enables unchanged.
- R8: The permit pin passes through two flops. A pin level applied before clock edge k is in effect from edge k+2. While a low level is in effect, both burst enables are zero from edge k+2 onward and writes to them are ignored.
- R9: `rd_data` is the register word while `io_rd` is high and the offset equals `CFG_OFS`, and zero otherwise. Bits 31..16 are always zero, so a 16-bit access in word mode returns the whole register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset request (no effect on this register) |
| stop_cmd | input | 1 | Stop command (no effect on this register) |
| burst_permit | input | 1 | External burst permit pin, asynchronous |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_ofs | input | OFS_W | Offset of the access from the I/O base |
| io_be | input | 4 | Byte enables of the access |
| io_wdata | input | 32 | Host write data |
| rd_data | output | 32 | Read-back data |
| dword_mode | output | 1 | 32-bit I/O mode flag |
| burst_rd_en | output | 1 | Linear burst enable for memory reads |
| burst_wr_en | output | 1 | Linear burst enable for memory writes |

## Verification
The bench builds the block with its default parameters: a 5-bit offset, the mode trigger at 0x10 and the register at 0x12. With these offsets, accesses to the trigger, to the register and to unrelated offsets can all be placed next to each other in a single run. This reaches the cases where a near-miss byte-enable pattern or a read of the trigger offset must leave the mode flag clear. It also covers the case where a write to the register itself carries a set bit 7 and must not set the flag. Permit-pin toggles are placed around burst writes so that the two-edge synchronizer delay and the ignored writes while the pin is low are compared edge by edge.

// File: rtl/bus_mode_cfg.sv
module bus_mode_cfg #(
  parameter int OFS_W    = 5,
  parameter int MODE_OFS = 16,
  parameter int CFG_OFS  = 18
) (
  input  logic             clk,
  input  logic             hrst_n,
  input  logic             soft_rst,
  input  logic             stop_cmd,
  input  logic             burst_permit,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [OFS_W-1:0] io_ofs,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      rd_data,
  output logic             dword_mode,
  output logic             burst_rd_en,
  output logic             burst_wr_en
);
  localparam logic [OFS_W-1:0] ModeAddr = OFS_W'(MODE_OFS);
  localparam logic [OFS_W-1:0] CfgAddr  = OFS_W'(CFG_OFS);

  logic permit_s1, permit_s2;
  logic mode_q, brd_q, bwr_q;

  wire mode_hit = io_wr && (io_ofs == ModeAddr) && (io_be == 4'hF);
  wire cfg_wr   = io_wr && (io_ofs == CfgAddr) && io_be[0];
  wire cfg_rd   = io_rd && (io_ofs == CfgAddr);

  always_ff @(posedge clk or negedge hrst_n)
    if (!hrst_n) {permit_s1, permit_s2} <= 2'b00;
    else         {permit_s1, permit_s2} <= {burst_permit, permit_s1};

  always_ff @(posedge clk or negedge hrst_n)
    if (!hrst_n)       mode_q <= 1'b0;
    else if (mode_hit) mode_q <= 1'b1;

  always_ff @(posedge clk or negedge hrst_n)
    if (!hrst_n)         {brd_q, bwr_q} <= 2'b00;
    else if (!permit_s2) {brd_q, bwr_q} <= 2'b00;
    else if (cfg_wr)     {brd_q, bwr_q} <= io_wdata[6:5];

  wire [15:0] word = {7'd0, 1'b1, mode_q, brd_q, bwr_q, 5'd0};

  assign rd_data     = cfg_rd ? {16'd0, word} : 32'd0;
  assign dword_mode  = mode_q;
  assign burst_rd_en = brd_q;
  assign burst_wr_en = bwr_q;

  p_marker_r1: assert property (@(posedge clk) disable iff (!hrst_n)
    cfg_rd |-> rd_data[8]);

  p_mode_cause_r2: assert property (@(posedge clk) disable iff (!hrst_n)
    $rose(dword_mode) |-> $past(io_wr && io_ofs == ModeAddr && io_be == 4'hF));

  p_mode_sticky_r5: assert property (@(posedge clk) disable iff (!hrst_n)
    dword_mode |=> dword_mode);

  p_burst_forced_r8: assert property (@(posedge clk) disable iff (!hrst_n)
    !permit_s2 |=> !burst_rd_en && !burst_wr_en);

  p_soft_keep_r7: assert property (@(posedge clk) disable iff (!hrst_n)
    (soft_rst || stop_cmd) && !io_wr && permit_s2
      |=> $stable({burst_rd_en, burst_wr_en}));

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!hrst_n)
    rd_data[31:16] == 16'd0);
endmodule

// File: tb/tb_bus_mode_cfg.sv
module tb_bus_mode_cfg;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, hrst_n = 0, soft_rst = 0, stop_cmd = 0, burst_permit = 0;
  logic io_wr = 0, io_rd = 0;
  logic [4:0] io_ofs = 0;
  logic [3:0] io_be = 0;
  logic [31:0] io_wdata = 0;
  logic [31:0] rd_data;
  logic dword_mode, burst_rd_en, burst_wr_en;

  bus_mode_cfg dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  string req = "R1";
  int m_mode = 0, m_brd = 0, m_bwr = 0, m_p1 = 0, m_p2 = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    if (io_rd && io_ofs == 5'h12)
      return 32'h100 | (m_mode << 7) | (m_brd << 6) | (m_bwr << 5);
    return 0;
  endfunction

  task automatic compare_all();
    chk("mode", dword_mode, m_mode);
    chk("brd", burst_rd_en, m_brd);
    chk("bwr", burst_wr_en, m_bwr);
    chk("rdata", rd_data, exp_rd());
  endtask

  task automatic step(bit wr, bit rd, int ofs, int be, int data, bit pin, bit srst, bit stp);
    io_wr = wr; io_rd = rd; io_ofs = 5'(ofs); io_be = 4'(be);
    io_wdata = data; burst_permit = pin; soft_rst = srst; stop_cmd = stp;
    @(posedge clk);
    if (wr && ofs == 16 && be == 15) m_mode = 1;
    if (m_p2 == 0) begin m_brd = 0; m_bwr = 0; end
    else if (wr && ofs == 18 && be[0]) begin m_brd = data[6]; m_bwr = data[5]; end
    m_p2 = m_p1; m_p1 = pin;
    @(negedge clk);
    compare_all();
  endtask

  task automatic hard_reset();
    hrst_n = 0; m_mode = 0; m_brd = 0; m_bwr = 0; m_p1 = 0; m_p2 = 0;
    #(CLK_PERIOD); @(negedge clk);
    compare_all();
    hrst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    req = "R2"; hard_reset();
    req = "R1"; step(0,1,18,3,0,1,0,0); step(0,1,18,3,0,1,0,0);
    req = "R9"; step(0,1,17,3,0,1,0,0); step(0,0,18,3,0,1,0,0);
    req = "R3";
    step(1,0,16,7,32'hFFFF,1,0,0); step(1,0,16,3,0,1,0,0);
    step(0,1,16,15,0,1,0,0); step(1,0,17,15,0,1,0,0);
    req = "R4"; step(1,0,18,15,32'h80,1,0,0);
    req = "R6"; step(1,0,18,1,32'h40,1,0,0); step(0,1,18,3,0,1,0,0);
    step(1,0,18,1,32'h20,1,0,0); step(1,0,18,2,32'h60,1,0,0);
    step(1,0,18,15,32'h60,1,0,0); step(0,1,18,15,0,1,0,0);
    req = "R7"; step(0,1,18,3,0,1,1,0); step(0,1,18,3,0,1,0,1);
    req = "R2"; step(1,0,16,15,0,1,0,0); step(0,1,18,15,0,1,0,0);
    req = "R4"; step(1,0,18,15,32'h60,1,0,0);
    req = "R5"; step(0,0,0,0,0,1,1,0); step(0,0,0,0,0,1,0,1);
    step(0,0,0,0,0,1,1,1); step(0,1,18,15,0,1,0,0);
    req = "R8";
    step(0,0,0,0,0,0,0,0); step(0,1,18,3,0,0,0,0);
    step(0,1,18,3,0,0,0,0); step(1,0,18,15,32'h60,0,0,0);
    step(0,1,18,3,0,1,0,0); step(1,0,18,1,32'h60,1,0,0);
    step(1,0,18,1,32'h60,1,0,0); step(0,1,18,3,0,1,0,0);
    step(1,0,18,1,32'h40,0,0,0); step(1,0,18,1,32'h60,1,0,0);
    step(0,1,18,3,0,1,0,0);
    req = "R5"; hard_reset(); step(0,1,18,3,0,1,0,0);
    req = "R9"; step(0,1,18,3,0,1,0,0); step(0,1,3,15,0,1,0,0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule